// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

The selector decides, every clock cycle, which of several hardware threads gives the next instruction to one shared pipeline. It keeps a program counter for each thread. It outputs the chosen thread number, that thread's program counter and a valid flag. After an issue, the chosen thread's counter moves forward by one instruction word. A redirect from the back end replaces a thread's counter instead.

A configuration input picks one of two scheduling modes. In interleaved (fine-grained) mode, the choice can change every cycle. A rotating pointer visits the threads in turn and passes over any thread that cannot issue. In block (coarse-grained) mode, one thread keeps the pipeline until it reports a costly stall, such as a second-level cache miss. The selector then moves to another ready thread. In the cycle after the move it raises a one-cycle flush request and issues nothing, so the pipeline can be emptied before the new thread fills it.

An optional preferred thread can be named. When that thread is able to issue, it wins the choice. The other threads run only in cycles where the preferred thread is blocked.

Top module: `mt_thread_sel`

## Requirements
- R1: After reset no flush is requested, the rotating pointer points at thread 0, and thread i's program counter is i times PC_STRIDE (0x1000 by default). With no stalls in interleaved mode, the first issue is thread 0 at PC 0 and the second is thread 1 at PC 0x1000.
- R2: In interleaved mode (`coarse_mode`=0), the output is combinational. The selected thread is the first eligible thread found by counting upward from the rotating pointer, wrapping at NTHR. After an issue, the pointer moves to the thread after the one just selected.
- R3: A thread is eligible only when three things hold: its `stall` bit is 0, it has no pending long stall, and no long-stall event names it in the current cycle. A thread that is not eligible is never issued in either mode.
- R4: When no thread is eligible in interleaved mode, `sel_valid` is 0 and the rotating pointer keeps its value.
- R5: In interleaved mode, when `pref_en` is 1 and thread `pref_tid` is eligible, that thread is selected. When it is not eligible, selection falls back to the R2 rule.
- R6: In block mode, only the current thread can issue. A short stall of that thread (its `stall` bit alone) gives `sel_valid`=0 and no change of thread or flush. The current thread is the last thread selected in interleaved mode, or the target of the last switch.
- R7: In block mode, a switch happens in a cycle when all of the following hold: the current thread has a long-stall event or a pending long stall, some thread is eligible, and no flush is in progress. The new thread is the preferred thread if `pref_en` is set and that thread is eligible. Otherwise it is the first eligible thread counting upward from the old current thread plus one.
- R8: `flush` is 1 for exactly the one cycle after a switch, and `sel_valid` is 0 in that cycle. The new thread can issue from the following cycle.
- R9: A long-stall event (`lstall_valid` with `lstall_tid`) makes that thread's long stall pending. The pending stall clears at the end of any cycle in which the thread's `stall` bit is 0 and no event names it. The thread is eligible again from the next cycle.
- R10: A redirect (`redir_valid[i]`) loads `redir_pc` slice i into thread i's program counter at the next clock edge. This takes priority over the advance. Otherwise, each issue of a thread adds 4 to its counter.
- R11: In block mode, if the current thread takes a long stall while no other thread is eligible, there is no switch and no flush. The switch happens in the first later cycle in which some thread becomes eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coarse_mode | input | 1 | 0 = interleave every cycle, 1 = switch only on a long stall |
| stall | input | NTHR | Per-thread stall flags |
| lstall_valid | input | 1 | A long-latency stall event is reported this cycle |
| lstall_tid | input | TIDW | Thread the long-stall event belongs to |
| redir_valid | input | NTHR | Per-thread program counter overwrite strobes |
| redir_pc | input | NTHR*PCW | New program counters, thread i in slice i |
| pref_en | input | 1 | Enables the preferred thread |
| pref_tid | input | TIDW | Preferred thread number |
| sel_valid | output | 1 | An instruction fetch is issued this cycle |
| sel_tid | output | TIDW | Selected thread |
| sel_pc | output | PCW | Program counter of the selected thread |
| flush | output | 1 | One-cycle pipeline flush request after a block-mode switch |

## Verification
The table phase runs interleaved mode with different stall patterns. With no stalls it shows plain rotation. A single stalled thread shows the skip. An all-stalled cycle followed by release shows that the pointer holds its value. Preferred-thread cases with the preferred thread ready and then stalled show priority and fall-back. Directed tests follow:
- Redirects, one on an idle thread and one on the issuing thread, show that a redirect beats the advance.
- In block mode, a short stall is kept apart from a long stall. A switch target is chosen where the rotating choice and the preferred choice differ.
- A long stall with no other thread ready shows that the switch waits.
- A return to interleaved mode shows that a pending long stall blocks a thread until its flag falls.

// File: rtl/mt_thread_sel.sv
module mt_thread_sel #(
  parameter int NTHR = 4,
  parameter int PCW = 32,
  parameter logic [PCW-1:0] PC_STRIDE = 'h1000,
  localparam int TIDW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                coarse_mode,
  input  logic [NTHR-1:0]     stall,
  input  logic                lstall_valid,
  input  logic [TIDW-1:0]     lstall_tid,
  input  logic [NTHR-1:0]     redir_valid,
  input  logic [NTHR*PCW-1:0] redir_pc,
  input  logic                pref_en,
  input  logic [TIDW-1:0]     pref_tid,
  output logic                sel_valid,
  output logic [TIDW-1:0]     sel_tid,
  output logic [PCW-1:0]      sel_pc,
  output logic                flush
);

  logic [PCW-1:0]  pc_q [NTHR];
  logic [NTHR-1:0] lpend_q, ev, ready;
  logic [TIDW-1:0] rr_q, cur_q, cand;
  logic            flush_q, any_ready, pref_ok, do_switch;

  function automatic logic [TIDW-1:0] rr_pick(input logic [NTHR-1:0] rdy, input int base);
    logic [TIDW-1:0] res;
    res = '0;
    for (int k = NTHR - 1; k >= 0; k--) begin
      if (rdy[(base + k) % NTHR]) res = TIDW'((base + k) % NTHR);
    end
    return res;
  endfunction

  for (genvar i = 0; i < NTHR; i++) begin : g_ev
    assign ev[i] = lstall_valid && (lstall_tid == TIDW'(i));
  end

  assign ready     = ~(stall | lpend_q | ev);
  assign any_ready = |ready;
  assign pref_ok   = pref_en && ready[pref_tid];
  assign cand      = pref_ok ? pref_tid
                   : rr_pick(ready, coarse_mode ? int'(cur_q) + 1 : int'(rr_q));
  assign do_switch = coarse_mode && !flush_q && (lpend_q[cur_q] || ev[cur_q]) && any_ready;

  assign sel_valid = coarse_mode ? (!flush_q && ready[cur_q]) : any_ready;
  assign sel_tid   = coarse_mode ? cur_q : cand;
  assign sel_pc    = pc_q[sel_tid];
  assign flush     = flush_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_q <= 1'b0;
      cur_q   <= '0;
      rr_q    <= '0;
      lpend_q <= '0;
    end else begin
      flush_q <= do_switch;
      lpend_q <= ev | (lpend_q & stall);
      if (do_switch || (!coarse_mode && any_ready)) cur_q <= cand;
      if (!coarse_mode && any_ready)
        rr_q <= (int'(cand) == NTHR - 1) ? '0 : cand + 1'b1;
    end
  end

  for (genvar i = 0; i < NTHR; i++) begin : g_pc
    always_ff @(posedge clk) begin
      if (!rst_n) pc_q[i] <= PCW'(i) * PC_STRIDE;
      else if (redir_valid[i]) pc_q[i] <= redir_pc[i*PCW +: PCW];
      else if (sel_valid && sel_tid == TIDW'(i)) pc_q[i] <= pc_q[i] + PCW'(4);
    end

    p_redir_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid[i] |=> pc_q[i] == $past(redir_pc[i*PCW +: PCW]));
    p_pc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid && sel_tid == TIDW'(i) && !redir_valid[i] |=> pc_q[i] == $past(sel_pc) + PCW'(4));
  end

  p_flush_no_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !sel_valid);
  p_flush_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);
  p_pick_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> !stall[sel_tid] && !lpend_q[sel_tid]);
  p_all_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !coarse_mode && (&stall) |-> !sel_valid);
  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !coarse_mode && (&stall) |=> rr_q == $past(rr_q));
  p_pref_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !coarse_mode && pref_en && !stall[pref_tid] && !lpend_q[pref_tid] && !(lstall_valid && lstall_tid == pref_tid)
    |-> sel_valid && sel_tid == pref_tid);
  p_coarse_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_mode && sel_valid |=> !(coarse_mode && sel_valid && sel_tid != $past(sel_tid)));

endmodule

// File: tb/mt_thread_sel_tb_top.sv
module mt_thread_sel_tb_top;
  localparam int N = 4;
  localparam int W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic coarse_mode = 1'b0, lstall_valid = 1'b0, pref_en = 1'b0;
  logic [N-1:0] stall = '0, redir_valid = '0;
  logic [1:0] lstall_tid = '0, pref_tid = '0;
  logic [N*W-1:0] redir_pc = '0;
  logic sel_valid, flush;
  logic [1:0] sel_tid;
  logic [W-1:0] sel_pc;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  mt_thread_sel #(.NTHR(N), .PCW(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .coarse_mode(coarse_mode), .stall(stall),
    .lstall_valid(lstall_valid), .lstall_tid(lstall_tid), .redir_valid(redir_valid),
    .redir_pc(redir_pc), .pref_en(pref_en), .pref_tid(pref_tid),
    .sel_valid(sel_valid), .sel_tid(sel_tid), .sel_pc(sel_pc), .flush(flush));

  // {coarse, stall[3:0], pref_en, pref_tid, exp_valid, exp_tid, exp_pc}
  localparam logic [42:0] VEC [10] = '{
    {1'b0, 4'b0000, 1'b0, 2'd0, 1'b1, 2'd0, 32'h0000},   // R1 R2
    {1'b0, 4'b0000, 1'b0, 2'd0, 1'b1, 2'd1, 32'h1000},   // R1 R2
    {1'b0, 4'b0100, 1'b0, 2'd0, 1'b1, 2'd3, 32'h3000},   // R3 skip
    {1'b0, 4'b0001, 1'b0, 2'd0, 1'b1, 2'd1, 32'h1004},   // R2 wrap
    {1'b0, 4'b1111, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0000},   // R4
    {1'b0, 4'b0000, 1'b0, 2'd0, 1'b1, 2'd2, 32'h2000},   // R4 pointer held
    {1'b0, 4'b0000, 1'b1, 2'd1, 1'b1, 2'd1, 32'h1008},   // R5
    {1'b0, 4'b0010, 1'b1, 2'd1, 1'b1, 2'd2, 32'h2004},   // R5 fall back
    {1'b0, 4'b0000, 1'b0, 2'd0, 1'b1, 2'd3, 32'h3004},   // R2
    {1'b0, 4'b0000, 1'b0, 2'd0, 1'b1, 2'd0, 32'h0004}    // R2 R10
  };

  task automatic chk(input string tag, input logic ev, input logic [1:0] et,
                     input logic [W-1:0] ep, input logic ef);
    #1;
    checks++;
    if (sel_valid !== ev || flush !== ef || (ev && (sel_tid !== et || sel_pc !== ep))) begin
      fails++;
      $display("FAIL %s: valid=%0b tid=%0d pc=%h flush=%0b, expected valid=%0b tid=%0d pc=%h flush=%0b",
               tag, sel_valid, sel_tid, sel_pc, flush, ev, et, ep, ef);
    end
    @(negedge clk);
  endtask

  task automatic drv(input logic cm, input logic [3:0] st, input logic lv, input logic [1:0] lt,
                     input logic pe, input logic [1:0] pt);
    coarse_mode = cm; stall = st; lstall_valid = lv; lstall_tid = lt; pref_en = pe; pref_tid = pt;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (flush !== 1'b0) begin
      fails++;
      $display("FAIL R1: flush=%0b during reset, expected 0", flush);
    end
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 10; i++) begin
      drv(VEC[i][42], VEC[i][41:38], 1'b0, 2'd0, VEC[i][37], VEC[i][36:35]);
      chk($sformatf("R2 R3 R4 R5 vector %0d", i), VEC[i][34], VEC[i][33:32], VEC[i][31:0], 1'b0);
    end

    // R10 redirects
    drv(0, 4'b0000, 0, 0, 0, 0);
    redir_valid = 4'b0100; redir_pc[2*W +: W] = 32'h5000;
    chk("R10 issue during redirect of other thread", 1, 1, 32'h100c, 0);
    redir_valid = '0;
    chk("R10 redirected pc", 1, 2, 32'h5000, 0);
    redir_valid = 4'b1000; redir_pc[3*W +: W] = 32'h6000;
    chk("R10 issue with own redirect", 1, 3, 32'h3008, 0);
    redir_valid = '0;
    chk("R2 wrap to thread 0", 1, 0, 32'h0008, 0);
    drv(0, 4'b0101, 0, 0, 0, 0);
    chk("R3 skip stalled", 1, 1, 32'h1010, 0);
    drv(0, 4'b0111, 0, 0, 0, 0);
    chk("R10 redirect beats advance", 1, 3, 32'h6000, 0);

    // R6 block mode hold
    drv(1, 4'b0000, 0, 0, 0, 0);
    chk("R6 block mode keeps thread", 1, 3, 32'h6004, 0);
    chk("R6 block mode keeps thread", 1, 3, 32'h6008, 0);
    drv(1, 4'b1000, 0, 0, 0, 0);
    chk("R6 short stall bubble", 0, 0, 0, 0);
    drv(1, 4'b0000, 0, 0, 0, 0);
    chk("R6 resume after short stall", 1, 3, 32'h600c, 0);

    // R7 R8 switch
    drv(1, 4'b1000, 1, 3, 0, 0);
    chk("R7 long stall cycle", 0, 0, 0, 0);
    drv(1, 4'b1000, 0, 0, 0, 0);
    chk("R8 flush pulse", 0, 0, 0, 1);
    chk("R7 new thread issues", 1, 0, 32'h000c, 0);
    chk("R8 flush dropped", 1, 0, 32'h0010, 0);
    drv(1, 4'b0000, 0, 0, 0, 0);
    chk("R6 stays after other thread recovers", 1, 0, 32'h0014, 0);

    // R11 no other ready
    drv(1, 4'b1111, 1, 0, 0, 0);
    chk("R11 long stall, none ready", 0, 0, 0, 0);
    drv(1, 4'b1111, 0, 0, 0, 0);
    chk("R11 no flush while none ready", 0, 0, 0, 0);
    drv(1, 4'b0111, 0, 0, 0, 0);
    chk("R11 switch when thread 3 ready", 0, 0, 0, 0);
    chk("R11 R8 flush", 0, 0, 0, 1);
    chk("R11 thread 3 issues", 1, 3, 32'h6010, 0);

    // R7 preferred target
    drv(1, 4'b1001, 1, 3, 1, 2);
    chk("R7 long stall with preferred", 0, 0, 0, 0);
    drv(1, 4'b1001, 0, 0, 1, 2);
    chk("R7 R8 flush", 0, 0, 0, 1);
    chk("R7 preferred thread chosen", 1, 2, 32'h5004, 0);

    // R9 pending clears
    drv(0, 4'b0000, 0, 0, 0, 0);
    chk("R9 pending threads still blocked", 1, 1, 32'h1014, 0);
    chk("R2 next", 1, 2, 32'h5008, 0);
    chk("R9 thread 3 eligible again", 1, 3, 32'h6014, 0);
    chk("R9 thread 0 eligible again", 1, 0, 32'h0018, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule